// File: doc/BRIEF.md
# Bus Handoff Request/Grant Arbiter

This block is the processor side of a bus handoff to other local masters. Each channel is one shared, active-low, open-drain line with a pull-up. The line carries three one-clock pulses in turn. The requesting master pulses it low to ask for the bus. The block pulses it low to grant the bus. The master pulses it low again when it is finished with the bus. After the grant the block floats the bus and raises a hold-acknowledge flag. It reclaims the bus one clock after the release pulse. That clock is a dead clock in which no new grant may start.

The block takes the sampled line levels and a description of the current bus cycle. This description gives the T-state code, a locked-instruction flag, a flag for the first acknowledge of an interrupt pair, and a flag for the first half of a word that is split across two transfers. On an idle bus, a pending request is granted in the next clock. During an active cycle the grant can only come in T4, and only when the release conditions hold. A request that cannot be granted stays pending until an eligible point. The lowest-numbered channel wins when several requests are eligible.

Top module: `rgx_arbiter`

## Requirements
- R1: After reset, no line is driven, and bus float and hold acknowledge are both 0.
- R2: A low level sampled on a channel's line while the bus is idle (T-state code 0) and no lock is active produces a grant in the next clock. The grant is a drive-low on that channel's line for exactly one clock.
- R3: In every clock after a grant clock, bus float and hold acknowledge are both 1, up to and including the clock in which the release pulse is sampled.
- R4: The block's own grant pulse, seen on the line in the grant clock, is neither taken as a release nor as a new request.
- R5: In the clock after the owning channel's release pulse, float and hold acknowledge are 0 and no grant is issued (dead clock). A grant may come in the clock after that.
- R6: When both channels are eligible in the same clock, channel 0 is granted and channel 1 stays pending.
- R7: During an active cycle, a grant is issued only in T4 (code 4). A request sampled in T4, T1 or T2 (codes 4, 1, 2) is granted at the next T4 if no blocking flag is set.
- R8: A request sampled in T3 or TW (codes 3, 5) is not granted in the T4 of that same cycle. It is granted at the following T4.
- R9: At T4, a set lock, first-acknowledge or split-first flag withholds the grant, and the request remains pending. Lock also withholds the grant on an idle bus.
- R10: During a hold, a pulse on the non-owning line does not end the hold. That pulse is kept as a pending request and granted after the dead clock.
- R11: At most one line is driven at a time, and no line is driven during a hold or the dead clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rg_n_i | input | CH | Sampled line levels, low = pulse |
| tstate_i | input | 3 | T-state code: 0 idle, 1 T1, 2 T2, 3 T3, 4 T4, 5 TW |
| lock_i | input | 1 | A locked instruction is running |
| first_ack_i | input | 1 | Current cycle is the first acknowledge of an interrupt pair |
| split_first_i | input | 1 | Current cycle is the first half of a split odd-address word |
| rg_drive_o | output | CH | Drive-low enable per line (grant pulse) |
| bus_float_o | output | 1 | Bus and control lines floated |
| hold_ack_o | output | 1 | Hold acknowledge state |

## Verification
The embedded assertions check several rules on every cycle. At most one line is driven at a time. A grant is always followed by float and hold. A grant never appears while the bus is held, in the dead clock, outside idle or T4, or under lock. The dead clock that follows a dropped hold carries no grant. Other rules need the bench's scenarios. These are the cycle at which a late or blocked request finally gets its grant, channel priority, the rejection of the block's own pulse as a release, and how a pulse on the foreign line during a hold is pended and served later.

// File: rtl/rgx_pkg.sv
package rgx_pkg;

  typedef enum logic [2:0] {
    TS_IDLE = 3'd0,
    TS_T1   = 3'd1,
    TS_T2   = 3'd2,
    TS_T3   = 3'd3,
    TS_T4   = 3'd4,
    TS_TW   = 3'd5
  } tstate_e;

  typedef enum logic [1:0] {
    HS_OWN  = 2'd0,
    HS_HELD = 2'd1,
    HS_DEAD = 2'd2
  } hstate_e;

  // a request seen in this T-state counts as "on or before T2" for the T4 ahead
  function automatic logic seen_early(input logic [2:0] t);
    return (t != TS_T3) && (t != TS_TW);
  endfunction

  // may a pending request be granted in this clock
  function automatic logic grant_window(input logic [2:0] t, input logic ripe,
                                        input logic lock, input logic fack,
                                        input logic split);
    return !lock && ((t == TS_IDLE) || ((t == TS_T4) && ripe && !fack && !split));
  endfunction

endpackage

// File: rtl/rgx_chan.sv
module rgx_chan
  import rgx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_n,
  input  logic       mask,
  input  logic       clr,
  input  logic [2:0] tstate,
  output logic       pend,
  output logic       ripe
);

  logic req_seen;
  assign req_seen = !line_n && !mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0;
      ripe <= 1'b0;
    end else if (clr) begin
      pend <= 1'b0;
      ripe <= 1'b0;
    end else begin
      pend <= pend | req_seen;
      if (req_seen && seen_early(tstate))
        ripe <= 1'b1;
      else if (tstate == TS_T4)
        ripe <= pend | req_seen;
    end
  end

endmodule

// File: rtl/rgx_ctrl.sv
module rgx_ctrl
  import rgx_pkg::*;
#(
  parameter int CH = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CH-1:0] line_n,
  input  logic [CH-1:0] pend,
  input  logic [CH-1:0] ripe,
  input  logic [2:0]    tstate,
  input  logic          lock,
  input  logic          fack,
  input  logic          split,
  output logic [CH-1:0] grant,
  output logic [CH-1:0] held_mask,
  output logic          bus_float,
  output logic          hold_ack
);

  hstate_e       st_q;
  logic [CH-1:0] owner_q;
  logic [CH-1:0] elig;
  logic          release_seen;
  logic          grant_any;

  function automatic logic [CH-1:0] lowest_one(input logic [CH-1:0] v);
    logic [CH-1:0] r;
    logic          found;
    r = '0;
    found = 1'b0;
    for (int k = 0; k < CH; k++) begin
      if (v[k] && !found) begin
        r[k] = 1'b1;
        found = 1'b1;
      end
    end
    return r;
  endfunction

  for (genvar g = 0; g < CH; g++) begin : g_elig
    assign elig[g] = pend[g] && grant_window(tstate, ripe[g], lock, fack, split);
  end

  assign grant        = (st_q == HS_OWN) ? lowest_one(elig) : '0;
  assign grant_any    = |grant;
  assign held_mask    = (st_q == HS_HELD) ? owner_q : '0;
  assign release_seen = (st_q == HS_HELD) && |(owner_q & ~line_n);
  assign bus_float    = (st_q == HS_HELD);
  assign hold_ack     = (st_q == HS_HELD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= HS_OWN;
      owner_q <= '0;
    end else begin
      unique case (st_q)
        HS_OWN:  if (grant_any) begin
                   st_q    <= HS_HELD;
                   owner_q <= grant;
                 end
        HS_HELD: if (release_seen) st_q <= HS_DEAD;
        HS_DEAD: st_q <= HS_OWN;
        default: st_q <= HS_OWN;
      endcase
    end
  end

  // R11
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  // R11
  no_grant_in_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_ack |-> (grant == '0));
  // R3
  grant_then_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_any |=> (bus_float && hold_ack));
  // R5
  dead_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_ack) |-> (grant == '0));
  // R7
  grant_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_any |-> (tstate == TS_IDLE || tstate == TS_T4));
  // R9
  lock_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock |-> !grant_any);

endmodule

// File: rtl/rgx_arbiter.sv
module rgx_arbiter
  import rgx_pkg::*;
#(
  parameter int CH = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CH-1:0] rg_n_i,
  input  logic [2:0]    tstate_i,
  input  logic          lock_i,
  input  logic          first_ack_i,
  input  logic          split_first_i,
  output logic [CH-1:0] rg_drive_o,
  output logic          bus_float_o,
  output logic          hold_ack_o
);

  logic [CH-1:0] pend;
  logic [CH-1:0] ripe;
  logic [CH-1:0] grant;
  logic [CH-1:0] held_mask;

  for (genvar g = 0; g < CH; g++) begin : g_chan
    rgx_chan u_chan (
      .clk    (clk),
      .rst_n  (rst_n),
      .line_n (rg_n_i[g]),
      .mask   (held_mask[g]),
      .clr    (grant[g]),
      .tstate (tstate_i),
      .pend   (pend[g]),
      .ripe   (ripe[g])
    );
  end

  rgx_ctrl #(.CH(CH)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_n    (rg_n_i),
    .pend      (pend),
    .ripe      (ripe),
    .tstate    (tstate_i),
    .lock      (lock_i),
    .fack      (first_ack_i),
    .split     (split_first_i),
    .grant     (grant),
    .held_mask (held_mask),
    .bus_float (bus_float_o),
    .hold_ack  (hold_ack_o)
  );

  assign rg_drive_o = grant;

endmodule

// File: tb/rgx_arbiter_tb.sv
module rgx_arbiter_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] ext = 2'b00;
  logic [2:0] ts = 3'd0;
  logic       lk = 1'b0, fa = 1'b0, sf = 1'b0;
  logic [1:0] line_n;
  logic [1:0] drv;
  logic       flt, hld;
  int         checks = 0;
  int         fails = 0;
  bit         done = 1'b0;

  typedef struct {
    logic [1:0] drv;
    logic       flt;
    logic       hld;
    string      tag;
  } exp_t;
  exp_t sb_q[$];

  always #2 clk = ~clk;

  // open-drain wire with pull-up
  assign line_n = ~(ext | drv);

  rgx_arbiter #(.CH(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .rg_n_i(line_n), .tstate_i(ts),
    .lock_i(lk), .first_ack_i(fa), .split_first_i(sf),
    .rg_drive_o(drv), .bus_float_o(flt), .hold_ack_o(hld)
  );

  task automatic cyc(input logic [1:0] e, input logic [2:0] t, input logic l,
                     input logic f, input logic s, input logic [1:0] xd,
                     input logic xf, input logic xh, input string tag);
    exp_t it;
    @(posedge clk);
    #1;
    ext = e; ts = t; lk = l; fa = f; sf = s;
    it.drv = xd; it.flt = xf; it.hld = xh; it.tag = tag;
    sb_q.push_back(it);
  endtask

  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      exp_t it;
      it = sb_q.pop_front();
      checks++;
      if (drv !== it.drv || flt !== it.flt || hld !== it.hld) begin
        fails++;
        $display("FAIL %s: drive=%b float=%b hold=%b expected drive=%b float=%b hold=%b",
                 it.tag, drv, flt, hld, it.drv, it.flt, it.hld);
      end
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    cyc(2'b00, 3'd0, 0,0,0, 2'b00, 0, 0, "R1 reset");
    cyc(2'b00, 3'd0, 0,0,0, 2'b00, 0, 0, "R1 reset");

    // R2 idle request on ch0; R10 foreign pulse during hold
    cyc(2'b01, 3'd0, 0,0,0, 2'b00, 0, 0, "R2 req");
    cyc(2'b00, 3'd0, 0,0,0, 2'b01, 0, 0, "R2 grant");
    cyc(2'b00, 3'd0, 0,0,0, 2'b00, 1, 1, "R3 R4 hold");
    cyc(2'b10, 3'd0, 0,0,0, 2'b00, 1, 1, "R10 foreign pulse");
    cyc(2'b00, 3'd0, 0,0,0, 2'b00, 1, 1, "R10 still held");
    cyc(2'b01, 3'd0, 0,0,0, 2'b00, 1, 1, "R3 release clock");
    cyc(2'b00, 3'd0, 0,0,0, 2'b00, 0, 0, "R5 dead");
    cyc(2'b00, 3'd0, 0,0,0, 2'b10, 0, 0, "R10 pended grant");
    cyc(2'b00, 3'd0, 0,0,0, 2'b00, 1, 1, "R3 hold ch1");
    cyc(2'b10, 3'd0, 0,0,0, 2'b00, 1, 1, "R3 release ch1");
    cyc(2'b00, 3'd0, 0,0,0, 2'b00, 0, 0, "R5 dead");
    cyc(2'b00, 3'd0, 0,0,0, 2'b00, 0, 0, "R11 quiet");

    // R6 priority
    cyc(2'b11, 3'd0, 0,0,0, 2'b00, 0, 0, "R6 both req");
    cyc(2'b00, 3'd0, 0,0,0, 2'b01, 0, 0, "R6 ch0 first");
    cyc(2'b00, 3'd0, 0,0,0, 2'b00, 1, 1, "R6 hold");
    cyc(2'b01, 3'd0, 0,0,0, 2'b00, 1, 1, "R6 release");
    cyc(2'b00, 3'd0, 0,0,0, 2'b00, 0, 0, "R5 dead blocks ch1");
    cyc(2'b00, 3'd0, 0,0,0, 2'b10, 0, 0, "R6 ch1 next");
    cyc(2'b10, 3'd0, 0,0,0, 2'b00, 1, 1, "R6 release ch1");
    cyc(2'b00, 3'd0, 0,0,0, 2'b00, 0, 0, "R5 dead");

    // R7 request at T1 granted in T4
    cyc(2'b01, 3'd1, 0,0,0, 2'b00, 0, 0, "R7 T1 req");
    cyc(2'b00, 3'd2, 0,0,0, 2'b00, 0, 0, "R7 T2");
    cyc(2'b00, 3'd3, 0,0,0, 2'b00, 0, 0, "R7 T3");
    cyc(2'b00, 3'd4, 0,0,0, 2'b01, 0, 0, "R7 T4 grant");
    cyc(2'b01, 3'd0, 0,0,0, 2'b00, 1, 1, "R7 hold release");
    cyc(2'b00, 3'd0, 0,0,0, 2'b00, 0, 0, "R5 dead");

    // R8 late request in T3
    cyc(2'b00, 3'd1, 0,0,0, 2'b00, 0, 0, "R8 T1");
    cyc(2'b00, 3'd2, 0,0,0, 2'b00, 0, 0, "R8 T2");
    cyc(2'b01, 3'd3, 0,0,0, 2'b00, 0, 0, "R8 T3 req");
    cyc(2'b00, 3'd4, 0,0,0, 2'b00, 0, 0, "R8 same T4 no grant");
    cyc(2'b00, 3'd1, 0,0,0, 2'b00, 0, 0, "R8 T1");
    cyc(2'b00, 3'd2, 0,0,0, 2'b00, 0, 0, "R8 T2");
    cyc(2'b00, 3'd5, 0,0,0, 2'b00, 0, 0, "R8 TW");
    cyc(2'b00, 3'd4, 0,0,0, 2'b01, 0, 0, "R8 next T4 grant");
    cyc(2'b01, 3'd0, 0,0,0, 2'b00, 1, 1, "R8 hold release");
    cyc(2'b00, 3'd0, 0,0,0, 2'b00, 0, 0, "R5 dead");

    // R9 blockers at T4 (ch1)
    cyc(2'b10, 3'd1, 0,0,0, 2'b00, 0, 0, "R9 T1 req");
    cyc(2'b00, 3'd2, 0,0,0, 2'b00, 0, 0, "R9 T2");
    cyc(2'b00, 3'd4, 1,0,0, 2'b00, 0, 0, "R9 lock at T4");
    cyc(2'b00, 3'd1, 0,0,0, 2'b00, 0, 0, "R9 T1");
    cyc(2'b00, 3'd4, 0,1,0, 2'b00, 0, 0, "R9 first ack at T4");
    cyc(2'b00, 3'd1, 0,0,0, 2'b00, 0, 0, "R9 T1");
    cyc(2'b00, 3'd4, 0,0,1, 2'b00, 0, 0, "R9 split at T4");
    cyc(2'b00, 3'd1, 0,0,0, 2'b00, 0, 0, "R9 T1");
    cyc(2'b00, 3'd4, 0,0,0, 2'b10, 0, 0, "R9 clean T4 grant");
    cyc(2'b10, 3'd0, 0,0,0, 2'b00, 1, 1, "R9 hold release");
    cyc(2'b00, 3'd0, 0,0,0, 2'b00, 0, 0, "R5 dead");

    // R9 lock on idle bus
    cyc(2'b01, 3'd0, 1,0,0, 2'b00, 0, 0, "R9 idle req lock");
    cyc(2'b00, 3'd0, 1,0,0, 2'b00, 0, 0, "R9 idle locked");
    cyc(2'b00, 3'd0, 0,0,0, 2'b01, 0, 0, "R9 idle unlocked grant");
    cyc(2'b00, 3'd0, 0,0,0, 2'b00, 1, 1, "R4 own pulse ignored");
    cyc(2'b01, 3'd0, 0,0,0, 2'b00, 1, 1, "R3 release");
    cyc(2'b00, 3'd0, 0,0,0, 2'b00, 0, 0, "R5 dead");
    cyc(2'b00, 3'd0, 0,0,0, 2'b00, 0, 0, "R11 idle");

    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule